// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier

This block models the control logic of an asynchronous-strobe DRAM. It samples the active-low row strobe, column strobe, write enable and output enable with a fast clock. At each falling edge of the row strobe, the order of the strobe edges decides what the cycle is: a normal access, a refresh of the row on the address pins, a refresh driven by the internal counter, a refresh tucked behind a finished read, self refresh, or entry to test mode. A small register array holds the data. Reads, early writes and read-modify-writes follow the same edge-order rules, and so does fast page mode, where several column strobes fall within one row-strobe low period.

Refreshes are reported on a one-cycle strobe together with the row refreshed. The internal refresh row counter is twelve bits wide. The strobes are assumed to arrive synchronous to the sample clock.

Top module: `dram_cycle_decoder`

## Requirements
- R1: The row address is captured when the row strobe falls with the column strobe high. The column address is captured on every later column-strobe fall while the row strobe stays low, so several columns of one row can be read in one row-strobe period (page mode). `cyc_kind` shows 1 after such an access.
- R2: Early write: if write enable is low when the column strobe falls, `din` is stored at the latched row and column, and `dq_oe` stays 0 for that whole column-strobe pulse, even with output enable low.
- R3: Read: if write enable is high when the column strobe falls, the stored word appears on `dq_out`. `dq_oe` is 1 only while the column strobe and output enable are both low. It drops in the same sample as either one rises.
- R4: Read-modify-write: a fall of write enable during a read's column-strobe pulse stores `din` at that location. The output keeps showing the word read earlier.
- R5: If the row strobe falls with the column strobe high and rises again without any column-strobe fall, one refresh is reported for the row on the address pins, zero-extended to 12 bits. `cyc_kind` becomes 2 and `dq_oe` stays 0.
- R6: If the column strobe is low and write enable is high when the row strobe falls, and no read or write is being held over, one refresh of the internal counter row is reported. The counter then advances by one, the address pins are ignored and `cyc_kind` becomes 3.
- R7: The refresh counter is 0 after reset, is 12 bits wide and steps from 4095 to 0.
- R8: Hidden refresh: if the column strobe stays low after an access and the row strobe rises and falls again, each new fall reports a refresh of the counter row and advances the counter. `cyc_kind` becomes 4, and the read data stays on `dq_out` with `dq_oe` still 1 while output enable is low.
- R9: If write enable is also low at a counter-refresh row-strobe fall, `test_mode` becomes 1 and `cyc_kind` becomes 5. No refresh is reported and the counter keeps its value. The next address-row refresh or counter refresh clears `test_mode`.
- R10: If the row strobe is held low for SELF_ENTRY samples after a counter-refresh fall, `self_refresh` becomes 1 and `cyc_kind` becomes 6. After that a counter refresh is reported every SELF_INT samples. Both stop at the sample in which the row strobe is seen high.
- R11: After reset, `dq_oe`, `refresh_stb`, `test_mode` and `self_refresh` are 0 and `cyc_kind` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ROW_BITS | Multiplexed row/column address |
| din | input | DW | Write data |
| dq_out | output | DW | Read data |
| dq_oe | output | 1 | Read data is driven |
| cyc_kind | output | 3 | Last classification: 0 idle, 1 access, 2 address refresh, 3 counter refresh, 4 hidden, 5 test entry, 6 self refresh |
| refresh_stb | output | 1 | One-cycle refresh report |
| refresh_row | output | CNT_W | Row refreshed with the report |
| test_mode | output | 1 | Test mode active |
| self_refresh | output | 1 | Self refresh active |

## Verification
The bench uses a 16x16 array of 4-bit words and lowers SELF_ENTRY to 40 and SELF_INT to 10. With these values, entering self refresh and the exact number of internal refreshes within a 100-sample hold can be counted. The last interval ends on the same sample in which the row strobe rises, which tests that boundary. The default 12-bit counter is kept, and a run of counter refreshes carries it across the 4095-to-0 step.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;

  typedef enum logic [2:0] {
    KIND_IDLE     = 3'd0,
    KIND_ACCESS   = 3'd1,
    KIND_ADDR_REF = 3'd2,
    KIND_CNT_REF  = 3'd3,
    KIND_HIDDEN   = 3'd4,
    KIND_TEST     = 3'd5,
    KIND_SELF     = 3'd6
  } cyc_kind_e;

  // Classify a row-strobe fall from the strobe levels in the same sample.
  function automatic cyc_kind_e classify_ras_fall(input logic cas_low,
                                                  input logic we_low,
                                                  input logic held);
    if (!cas_low)     return KIND_ACCESS;
    else if (held)    return KIND_HIDDEN;
    else if (we_low)  return KIND_TEST;
    else              return KIND_CNT_REF;
  endfunction

endpackage

// File: rtl/strobe_sampler.sv
module strobe_sampler #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_n,
  output logic [N-1:0] fall,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_n <= '1;
    else        prev_n <= lvl_n;
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign fall[i] = prev_n[i] & ~lvl_n[i];
    assign rise[i] = ~prev_n[i] & lvl_n[i];
  end
endmodule

// File: rtl/cell_array.sv
module cell_array #(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 4,
  parameter int DW       = 4
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [ROW_BITS-1:0] wr_row,
  input  logic [COL_BITS-1:0] wr_col,
  input  logic [DW-1:0]       wr_data,
  input  logic [ROW_BITS-1:0] rd_row,
  input  logic [COL_BITS-1:0] rd_col,
  output logic [DW-1:0]       rd_data
);
  localparam int DEPTH = 1 << (ROW_BITS + COL_BITS);

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[{wr_row, wr_col}] <= wr_data;
  end

  assign rd_data = cells[{rd_row, rd_col}];
endmodule

// File: rtl/refresh_ctrl.sv
module refresh_ctrl #(
  parameter int CNT_W      = 12,
  parameter int SELF_ENTRY = 10000,
  parameter int SELF_INT   = 1560
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cbr_start,
  input  logic             hidden_start,
  input  logic             addr_ref_done,
  input  logic [CNT_W-1:0] addr_ref_row,
  input  logic             ras_n,
  input  logic             ras_rise,
  output logic             refresh_stb,
  output logic [CNT_W-1:0] refresh_row,
  output logic             self_refresh,
  output logic             self_enter
);
  localparam int LW = (SELF_ENTRY > 2) ? $clog2(SELF_ENTRY) : 1;
  localparam int IW = (SELF_INT > 2) ? $clog2(SELF_INT) : 1;
  localparam logic [LW-1:0] LAST_L = LW'(SELF_ENTRY - 1);
  localparam logic [IW-1:0] LAST_I = IW'(SELF_INT - 1);

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] cnt;
  logic [LW-1:0]    lcnt;
  logic [IW-1:0]    icnt;
  logic             cbr_active;
  logic             int_tick;
  logic             use_cnt;

  assign int_tick   = self_refresh & ~ras_rise & (icnt == LAST_I);
  assign self_enter = cbr_active & ~self_refresh & ~ras_rise & (lcnt == LAST_L);
  assign use_cnt    = cbr_start | hidden_start | int_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      refresh_stb <= 1'b0;
      refresh_row <= '0;
    end else begin
      refresh_stb <= use_cnt | addr_ref_done;
      if (use_cnt) begin
        refresh_row <= cnt;
        cnt         <= bump(cnt);
      end else if (addr_ref_done) begin
        refresh_row <= addr_ref_row;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cbr_active   <= 1'b0;
      self_refresh <= 1'b0;
      lcnt         <= '0;
      icnt         <= '0;
    end else begin
      if (cbr_start)     cbr_active <= 1'b1;
      else if (ras_rise) cbr_active <= 1'b0;

      if (cbr_start)                         lcnt <= '0;
      else if (cbr_active && !self_refresh)  lcnt <= lcnt + LW'(1);

      if (ras_rise)        self_refresh <= 1'b0;
      else if (self_enter) self_refresh <= 1'b1;

      if (self_enter)        icnt <= '0;
      else if (self_refresh) icnt <= (icnt == LAST_I) ? '0 : icnt + IW'(1);
    end
  end

  // R6: the counter moves only on a counter-sourced refresh
  p_cnt_still_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !use_cnt |=> $stable(cnt));

  // R10: self refresh never outlasts the row strobe
  p_self_ras_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    self_refresh |-> $past(!ras_n));
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
  import dram_dec_pkg::*;
#(
  parameter int ROW_BITS   = 4,
  parameter int COL_BITS   = 4,
  parameter int DW         = 4,
  parameter int CNT_W      = 12,
  parameter int SELF_ENTRY = 10000,
  parameter int SELF_INT   = 1560
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic                we_n,
  input  logic                oe_n,
  input  logic [ROW_BITS-1:0] addr,
  input  logic [DW-1:0]       din,
  output logic [DW-1:0]       dq_out,
  output logic                dq_oe,
  output logic [2:0]          cyc_kind,
  output logic                refresh_stb,
  output logic [CNT_W-1:0]    refresh_row,
  output logic                test_mode,
  output logic                self_refresh
);
  localparam int PAD = CNT_W - ROW_BITS;

  // Strobe edge events
  logic [2:0] fall, rise;
  logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall;

  strobe_sampler #(.N(3)) u_edges (
    .clk(clk), .rst_n(rst_n),
    .lvl_n({we_n, cas_n, ras_n}),
    .fall(fall), .rise(rise)
  );

  assign ras_fall = fall[0];
  assign cas_fall = fall[1];
  assign we_fall  = fall[2];
  assign ras_rise = rise[0];
  assign cas_rise = rise[1];

  // Cycle state
  logic                row_open, accessed, cas_hold;
  logic                rd_valid, early_q;
  logic [ROW_BITS-1:0] row_q;
  logic [COL_BITS-1:0] col_q;
  logic [DW-1:0]       dout_q;
  cyc_kind_e           kind_q;

  // Named events
  cyc_kind_e fall_kind;
  logic cbr_start, hidden_start, test_enter, addr_ref_done;
  logic access_col, early_wr, rd_start, rmw_wr;
  logic self_enter;

  assign fall_kind     = classify_ras_fall(~cas_n, ~we_n, cas_hold);
  assign cbr_start     = ras_fall && fall_kind == KIND_CNT_REF;
  assign hidden_start  = ras_fall && fall_kind == KIND_HIDDEN;
  assign test_enter    = ras_fall && fall_kind == KIND_TEST;
  assign addr_ref_done = ras_rise & row_open & ~accessed;
  assign access_col    = cas_fall & row_open & ~ras_n;
  assign early_wr      = access_col & ~we_n;
  assign rd_start      = access_col & we_n;
  assign rmw_wr        = we_fall & ~cas_fall & ~cas_n & rd_valid & row_open & ~ras_n;

  // Storage
  logic [DW-1:0]       rd_word;
  logic                wr_en;
  logic [COL_BITS-1:0] wr_col;

  assign wr_en  = early_wr | rmw_wr;
  assign wr_col = early_wr ? addr[COL_BITS-1:0] : col_q;

  cell_array #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DW(DW)) u_cells (
    .clk(clk), .wr_en(wr_en), .wr_row(row_q), .wr_col(wr_col), .wr_data(din),
    .rd_row(row_q), .rd_col(addr[COL_BITS-1:0]), .rd_data(rd_word)
  );

  refresh_ctrl #(.CNT_W(CNT_W), .SELF_ENTRY(SELF_ENTRY), .SELF_INT(SELF_INT)) u_ref (
    .clk(clk), .rst_n(rst_n),
    .cbr_start(cbr_start), .hidden_start(hidden_start),
    .addr_ref_done(addr_ref_done), .addr_ref_row({{PAD{1'b0}}, row_q}),
    .ras_n(ras_n), .ras_rise(ras_rise),
    .refresh_stb(refresh_stb), .refresh_row(refresh_row),
    .self_refresh(self_refresh), .self_enter(self_enter)
  );

  // Row / column capture and access tracking
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_open <= 1'b0;
      accessed <= 1'b0;
      cas_hold <= 1'b0;
      row_q    <= '0;
      col_q    <= '0;
    end else begin
      if (ras_fall && cas_n) begin
        row_open <= 1'b1;
        row_q    <= addr;
        accessed <= 1'b0;
      end else if (ras_rise) begin
        row_open <= 1'b0;
        accessed <= 1'b0;
      end else if (access_col) begin
        accessed <= 1'b1;
        col_q    <= addr[COL_BITS-1:0];
      end

      if (cas_n)                      cas_hold <= 1'b0;
      else if (ras_rise && accessed)  cas_hold <= 1'b1;
    end
  end

  // Read data path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      early_q  <= 1'b0;
      dout_q   <= '0;
    end else begin
      if (cas_rise) begin
        rd_valid <= 1'b0;
        early_q  <= 1'b0;
      end else if (rd_start) begin
        rd_valid <= 1'b1;
        dout_q   <= rd_word;
      end else if (early_wr) begin
        early_q  <= 1'b1;
      end
    end
  end

  // Mode and classification
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      test_mode <= 1'b0;
      kind_q    <= KIND_IDLE;
    end else begin
      if (test_enter)                      test_mode <= 1'b1;
      else if (cbr_start || addr_ref_done) test_mode <= 1'b0;

      if (self_enter)        kind_q <= KIND_SELF;
      else if (addr_ref_done) kind_q <= KIND_ADDR_REF;
      else if (ras_fall && !cas_n) kind_q <= fall_kind;
      else if (access_col)   kind_q <= KIND_ACCESS;
    end
  end

  assign dq_oe    = rd_valid & ~cas_n & ~oe_n;
  assign dq_out   = dout_q;
  assign cyc_kind = kind_q;

  // R2: an early write never drives the output
  p_early_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    early_q |-> !dq_oe);

  // R8: while the column strobe stays low, read data is held
  p_hidden_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && $past(!cas_n) && $past(rd_valid)) |-> (rd_valid && dout_q == $past(dout_q)));

  // R9: test-mode entry reports no refresh
  p_test_no_ref_r9: assert property (@(posedge clk) disable iff (!rst_n)
    test_enter |=> !refresh_stb);

  // R5: an address-row refresh never drives the output
  p_addr_ref_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ref_done |-> !dq_oe);
endmodule

// File: tb/sim_dram_cycle_decoder.sv
module sim_dram_cycle_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int RB = 4, CB = 4, DW = 4, CW = 12;
  localparam int S_ENTRY = 40, S_INT = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1, cas_n = 1, we_n = 1, oe_n = 1;
  logic [RB-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe, refresh_stb, test_mode, self_refresh;
  logic [2:0] cyc_kind;
  logic [CW-1:0] refresh_row;

  int checks = 0, errors = 0;
  int ref_cnt = 0;
  logic [CW-1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_cycle_decoder #(.ROW_BITS(RB), .COL_BITS(CB), .DW(DW), .CNT_W(CW),
                       .SELF_ENTRY(S_ENTRY), .SELF_INT(S_INT)) u0 (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .din(din), .dq_out(dq_out), .dq_oe(dq_oe),
    .cyc_kind(cyc_kind), .refresh_stb(refresh_stb), .refresh_row(refresh_row),
    .test_mode(test_mode), .self_refresh(self_refresh));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_cnt_row();
    exp_q.push_back(CW'(ref_cnt));
    ref_cnt = (ref_cnt + 1) % 4096;
  endtask

  // Scoreboard monitor: every reported refresh must match the next expected row
  always @(posedge clk) begin
    #1;
    if (rst_n && refresh_stb) begin
      if (exp_q.size() == 0) chk("R5/R6 unexpected refresh", 32'(refresh_row), 32'hFFFF);
      else chk("R5/R6/R8/R10 refresh row", 32'(refresh_row), 32'(exp_q.pop_front()));
    end
  end

  task automatic early_write(input int row, input int col, input int data);
    ras_n = 0; addr = RB'(row); tick();
    addr = RB'(col); din = DW'(data); we_n = 0; oe_n = 0; cas_n = 0; tick();
    chk("R2 early write output off", 32'(dq_oe), 0);
    tick();
    chk("R2 early write output off held", 32'(dq_oe), 0);
    cas_n = 1; we_n = 1; oe_n = 1; tick();
    ras_n = 1; tick();
  endtask

  task automatic cbr(input string tag);
    cas_n = 0; tick();
    ras_n = 0; addr = RB'(4'hA); push_cnt_row(); tick();
    chk({tag, " kind"}, 32'(cyc_kind), 3);
    ras_n = 1; tick();
    cas_n = 1; tick();
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick();
    chk("R11 dq_oe", 32'(dq_oe), 0);
    chk("R11 refresh_stb", 32'(refresh_stb), 0);
    chk("R11 kind", 32'(cyc_kind), 0);
    chk("R11 test_mode", 32'(test_mode), 0);
    chk("R11 self_refresh", 32'(self_refresh), 0);

    early_write(3, 5, 4'hA);
    early_write(3, 6, 4'h5);
    early_write(9, 1, 4'hC);

    // R3 read with OE and CAS gating
    ras_n = 0; addr = 3; tick();
    addr = 5; oe_n = 0; cas_n = 0; tick();
    chk("R3 read drive", 32'(dq_oe), 1);
    chk("R3 read data", 32'(dq_out), 32'hA);
    chk("R1 access kind", 32'(cyc_kind), 1);
    oe_n = 1; #1 chk("R3 OE rise releases", 32'(dq_oe), 0);
    oe_n = 0; #1 chk("R3 OE low drives", 32'(dq_oe), 1);
    cas_n = 1; #1 chk("R3 CAS rise releases", 32'(dq_oe), 0);
    tick();
    // R1 page mode: second column in the same row period
    addr = 6; cas_n = 0; tick();
    chk("R1 page second column", 32'(dq_out), 32'h5);
    cas_n = 1; oe_n = 1; ras_n = 1; tick(2);

    // R4 read-modify-write
    ras_n = 0; addr = 9; tick();
    addr = 1; oe_n = 0; cas_n = 0; tick();
    chk("R4 read before modify", 32'(dq_out), 32'hC);
    din = 4'h7; we_n = 0; tick();
    chk("R4 output keeps read data", 32'(dq_out), 32'hC);
    chk("R4 output still driven", 32'(dq_oe), 1);
    cas_n = 1; we_n = 1; oe_n = 1; ras_n = 1; tick(2);
    ras_n = 0; addr = 9; tick();
    addr = 1; oe_n = 0; cas_n = 0; tick();
    chk("R4 modified word", 32'(dq_out), 32'h7);
    cas_n = 1; oe_n = 1; ras_n = 1; tick(2);

    // R5 address-row refresh
    ras_n = 0; addr = 12; oe_n = 0; tick(2);
    exp_q.push_back(CW'(12));
    ras_n = 1; tick();
    chk("R5 kind", 32'(cyc_kind), 2);
    chk("R5 output open", 32'(dq_oe), 0);
    oe_n = 1; tick();

    // R6 counter refresh, address ignored
    cbr("R6");

    // R8 hidden refresh behind a read
    ras_n = 0; addr = 3; tick();
    addr = 6; oe_n = 0; cas_n = 0; tick();
    chk("R8 initial read", 32'(dq_out), 32'h5);
    for (int k = 0; k < 2; k++) begin
      ras_n = 1; tick();
      chk("R8 data held over RAS high", 32'(dq_oe), 1);
      ras_n = 0; addr = 4'hF; push_cnt_row(); tick();
      chk("R8 kind", 32'(cyc_kind), 4);
      chk("R8 still driven", 32'(dq_oe), 1);
      chk("R8 data kept", 32'(dq_out), 32'h5);
    end
    ras_n = 1; tick();
    cas_n = 1; oe_n = 1; tick();

    // R9 test-mode entry, then a counter refresh clears it
    cas_n = 0; we_n = 0; tick();
    ras_n = 0; tick();
    chk("R9 test_mode set", 32'(test_mode), 1);
    chk("R9 kind", 32'(cyc_kind), 5);
    ras_n = 1; tick();
    cas_n = 1; we_n = 1; tick();
    cbr("R9 exit");
    chk("R9 test_mode cleared", 32'(test_mode), 0);

    // R10 self refresh over a 100-sample hold
    cas_n = 0; tick();
    ras_n = 0;
    for (int k = 0; k < 6; k++) push_cnt_row();
    tick();
    tick(S_ENTRY - 1);
    chk("R10 not yet self", 32'(self_refresh), 0);
    tick();
    chk("R10 self entered", 32'(self_refresh), 1);
    chk("R10 kind", 32'(cyc_kind), 6);
    tick(59);
    ras_n = 1; tick();
    chk("R10 self ends", 32'(self_refresh), 0);
    cas_n = 1; tick(2);
    chk("R10 all internal refreshes seen", 32'(exp_q.size()), 0);

    // R7 wrap from 4095 to 0
    while (ref_cnt != 4095) cbr("R6 sweep");
    cas_n = 0; tick();
    ras_n = 0; push_cnt_row(); tick();
    chk("R7 row 4095", 32'(refresh_row), 32'd4095);
    ras_n = 1; tick(); cas_n = 1; tick();
    cas_n = 0; tick();
    ras_n = 0; push_cnt_row(); tick();
    chk("R7 wrapped to 0", 32'(refresh_row), 0);
    ras_n = 1; tick(); cas_n = 1; tick(2);

    chk("R6 scoreboard drained", 32'(exp_q.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule